// File: doc/BRIEF.md
# Parallel Memory Bus Operation Controller

This block is the bus-facing control unit of an asynchronous parallel non-volatile memory. The unit runs on a system clock. It samples four active-low control pins: chip select, output enable, write enable and device reset. Each pin passes through a two-flop synchronizer and a short-pulse filter. From the cleaned levels the block decides which bus operation is in force. It reports that operation as a code and drives the data output enable, which is the tri-state control of the data pins.

A write cycle ends when chip select or write enable rises, whichever comes first. At that point the block emits a one-cycle strobe and presents the address and data that were held during the write. Each accepted write starts a stand-in program/erase operation, modelled by a busy counter. While that operation runs, a deselect does not put the part into standby until the operation finishes. Pulling the device reset pin low aborts the operation and raises a sticky invalid-content flag.

During a selected read, a bus that stays quiet for a set number of cycles moves the block into automatic standby. The data stays driven while the read conditions hold. The next change on any control or address input leaves automatic standby.

Top module: `membus_opctl`

## Requirements
- R1: `op_code` gives the operation. The codes are read=0, write=1, output-disable=2, standby=3, auto-standby=4 and reset=5. They are tested in this order: reset, then deselect, then write, then auto-standby, then read, and output-disable otherwise.
- R2: `dq_oe` is high only when the cleaned levels are chip select low, output enable low, write enable high and reset high.
- R3: A write ends when chip select or write enable rises while reset stays high. On that edge, `wr_strobe` pulses high for exactly one cycle, and `wr_addr`/`wr_data` carry the values the pins held in the last cycle of the write.
- R4: With output enable high, `dq_oe` is low whatever the other pins are.
- R5: With chip select high, reset high and no busy operation, `op_code` is standby (3), `stby` is high and `dq_oe` is low.
- R6: An accepted write makes `busy` high for BUSY_CYC cycles. If chip select is high during that time, `op_code` is output-disable (2) and becomes standby (3) only once `busy` falls.
- R7: Auto-standby applies once chip select stays low, reset stays high, nothing is busy, no write is in progress, and the control and address inputs stay unchanged for IDLE_CYC cycles. Then `auto_sb` is high and `op_code` is 4. Any change on a control or address input clears it.
- R8: With reset low, `op_code` is 5 and `dq_oe` is low. A busy operation stops at once, and `aborted` goes high and stays high until the next accepted write.
- R9: After a system reset, `op_code` is standby (3), and `dq_oe`, `busy`, `aborted`, `auto_sb` and `wr_strobe` are all low. With the pins at read levels, `op_code` is read (0).
- R10: A control pin level lasting FILT_CYC cycles or fewer is ignored. A level held longer takes effect at the outputs 3+FILT_CYC clock edges after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip select pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| rp_n | input | 1 | Device reset pin, active low |
| addr | input | ADDR_W | Address pins |
| din | input | DATA_W | Data pins, input direction |
| dq_oe | output | 1 | Data pin drive enable (tri-state control) |
| op_code | output | 3 | Current bus operation code |
| stby | output | 1 | Standby indication |
| auto_sb | output | 1 | Automatic standby indication |
| wr_strobe | output | 1 | One-cycle write latch strobe |
| wr_addr | output | ADDR_W | Latched write address |
| wr_data | output | DATA_W | Latched write data |
| busy | output | 1 | Program/erase in progress |
| aborted | output | 1 | Last operation aborted by reset |

## Verification
A wrong filtered pin level or a wrong previous-cycle copy shows up within one clock as a wrong `op_code` or `dq_oe`. It also shows up as a strobe that is missing or doubled on a write termination. A stuck or miscounted idle counter shows up as `auto_sb` rising early, late or never, and this is visible no later than IDLE_CYC cycles after the last change. A wrong busy count or abort rule shows up as a busy window that is too long or too short, or a deselect that reports standby too early. It can also show as an `aborted` flag that stays clear after a reset during busy. The reference model compares every output on every cycle, so each of these shows as a mismatch in the cycle it first appears.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_OUTDIS = 3'd2,
    OP_STBY   = 3'd3,
    OP_AUTOSB = 3'd4,
    OP_RESET  = 3'd5
  } bus_op_e;

  localparam int unsigned NCTL   = 4;
  localparam int unsigned PIN_CE = 0;
  localparam int unsigned PIN_OE = 1;
  localparam int unsigned PIN_WE = 2;
  localparam int unsigned PIN_RP = 3;

endpackage

// File: rtl/membus_pin_filter.sv
module membus_pin_filter #(
  parameter int unsigned FILT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_clean
);

  localparam int unsigned CW = (FILT_CYC < 1) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYC);

  logic          s1_q, s2_q, clean_q, clean_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    clean_nx = clean_q;
    cnt_nx   = '0;
    if (s2_q != clean_q) begin
      if (cnt_q == CNT_MAX) begin
        clean_nx = s2_q;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      clean_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      s1_q    <= pin_raw;
      s2_q    <= s1_q;
      clean_q <= clean_nx;
      cnt_q   <= cnt_nx;
    end
  end

  assign pin_clean = clean_q;

  // R10
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q == clean_q) |=> $stable(clean_q));

endmodule

// File: rtl/membus_decode.sv
module membus_decode
  import membus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDLE_CYC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCTL-1:0]   ctl,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              busy,
  output bus_op_e           op,
  output logic              dq_oe,
  output logic              wr_edge,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              auto_sb
);

  localparam int unsigned IW = (IDLE_CYC < 1) ? 1 : $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYC);

  logic [NCTL-1:0]   ctl_d;
  logic [ADDR_W-1:0] adr_d;
  logic [DATA_W-1:0] dat_d;
  logic [IW-1:0]     idle_q, idle_nx;
  logic              stb_q;
  logic [ADDR_W-1:0] wa_q, wa_nx;
  logic [DATA_W-1:0] wd_q, wd_nx;
  logic              wr_now, wr_prev, activity;

  assign wr_now  = !ctl[PIN_CE] && !ctl[PIN_WE] && ctl[PIN_OE] && ctl[PIN_RP];
  assign wr_prev = !ctl_d[PIN_CE] && !ctl_d[PIN_WE] && ctl_d[PIN_OE] && ctl_d[PIN_RP];
  assign wr_edge = wr_prev && ctl[PIN_RP] && (ctl[PIN_CE] || ctl[PIN_WE]);
  assign activity = (ctl != ctl_d) || (addr_s != adr_d);
  assign auto_sb  = (idle_q == IDLE_MAX);

  always_comb begin
    if (activity || ctl[PIN_CE] || !ctl[PIN_RP] || busy || wr_now) begin
      idle_nx = '0;
    end else if (idle_q != IDLE_MAX) begin
      idle_nx = idle_q + 1'b1;
    end else begin
      idle_nx = idle_q;
    end
    wa_nx = wr_edge ? adr_d : wa_q;
    wd_nx = wr_edge ? dat_d : wd_q;
  end

  always_comb begin
    if (!ctl[PIN_RP])                        op = OP_RESET;
    else if (ctl[PIN_CE])                    op = busy ? OP_OUTDIS : OP_STBY;
    else if (wr_now)                         op = OP_WRITE;
    else if (auto_sb)                        op = OP_AUTOSB;
    else if (!ctl[PIN_OE] && ctl[PIN_WE])    op = OP_READ;
    else                                     op = OP_OUTDIS;
  end

  assign dq_oe = ctl[PIN_RP] && !ctl[PIN_CE] && !ctl[PIN_OE] && ctl[PIN_WE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_d  <= '1;
      adr_d  <= '0;
      dat_d  <= '0;
      idle_q <= '0;
      stb_q  <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      ctl_d  <= ctl;
      adr_d  <= addr_s;
      dat_d  <= data_s;
      idle_q <= idle_nx;
      stb_q  <= wr_edge;
      wa_q   <= wa_nx;
      wd_q   <= wd_nx;
    end
  end

  assign wr_strobe = stb_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R7
  autosb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !auto_sb);
  // R8
  reset_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[PIN_RP] |-> (!dq_oe && op == OP_RESET));
  // R2
  drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (op == OP_READ || op == OP_AUTOSB));

endmodule

// File: rtl/membus_engine.sv
module membus_engine #(
  parameter int unsigned BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_edge,
  input  logic rp_ok,
  output logic busy,
  output logic aborted
);

  localparam int unsigned BW = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);
  localparam logic [BW-1:0] LOAD = BW'((BUSY_CYC < 1) ? 0 : BUSY_CYC - 1);

  logic          busy_q, busy_nx, ab_q, ab_nx;
  logic [BW-1:0] cnt_q, cnt_nx;

  always_comb begin
    busy_nx = busy_q;
    cnt_nx  = cnt_q;
    ab_nx   = ab_q;
    if (!rp_ok) begin
      busy_nx = 1'b0;
      cnt_nx  = '0;
      ab_nx   = ab_q | busy_q;
    end else if (wr_edge && !busy_q) begin
      busy_nx = 1'b1;
      cnt_nx  = LOAD;
      ab_nx   = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_nx = 1'b0;
      else             cnt_nx  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      ab_q   <= 1'b0;
    end else begin
      busy_q <= busy_nx;
      cnt_q  <= cnt_nx;
      ab_q   <= ab_nx;
    end
  end

  assign busy    = busy_q;
  assign aborted = ab_q;

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rp_ok) |=> (!busy_q && ab_q));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_edge));

endmodule

// File: rtl/membus_opctl.sv
module membus_opctl
  import membus_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned FILT_CYC = 1,
  parameter int unsigned IDLE_CYC = 15,
  parameter int unsigned BUSY_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              rp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              dq_oe,
  output logic [2:0]        op_code,
  output logic              stby,
  output logic              auto_sb,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              aborted
);

  logic [NCTL-1:0]   pins_raw, ctl_f;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              wr_edge;
  bus_op_e           op;

  assign pins_raw = {rp_n, we_n, oe_n, ce_n};

  for (genvar gi = 0; gi < NCTL; gi++) begin : g_pin
    membus_pin_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_raw   (pins_raw[gi]),
      .pin_clean (ctl_f[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_s <= '0;
      data_s <= '0;
    end else begin
      addr_s <= addr;
      data_s <= din;
    end
  end

  membus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_CYC(IDLE_CYC)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl_f),
    .addr_s    (addr_s),
    .data_s    (data_s),
    .busy      (busy),
    .op        (op),
    .dq_oe     (dq_oe),
    .wr_edge   (wr_edge),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .auto_sb   (auto_sb)
  );

  membus_engine #(.BUSY_CYC(BUSY_CYC)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_edge (wr_edge),
    .rp_ok   (ctl_f[PIN_RP]),
    .busy    (busy),
    .aborted (aborted)
  );

  assign op_code = op;
  assign stby    = (op == OP_STBY);

endmodule

// File: tb/membus_opctl_test.sv
module membus_opctl_test;

  localparam int CLK_PER = 10;
  localparam int AW = 8, DW = 8, FILT = 1, IDLE = 15, BUSYN = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, rp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic dq_oe, stby, auto_sb, wr_strobe, busy, aborted;
  logic [2:0] op_code;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  membus_opctl #(.ADDR_W(AW), .DATA_W(DW), .FILT_CYC(FILT),
                 .IDLE_CYC(IDLE), .BUSY_CYC(BUSYN)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rp_n(rp_n), .addr(addr), .din(din), .dq_oe(dq_oe), .op_code(op_code),
    .stby(stby), .auto_sb(auto_sb), .wr_strobe(wr_strobe),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .aborted(aborted));

  // reference model: pin histories in queues, behavioural counters
  logic [3:0]    ph[$];
  logic [AW-1:0] ah[$];
  logic [DW-1:0] dh[$];
  logic [3:0] m_lvl, m_prv;
  int  m_run[4];
  int  m_idle, m_left;
  bit  m_busy, m_ab, m_stb;
  logic [AW-1:0] m_wa;
  logic [DW-1:0] m_wd;

  function automatic bit wcond(logic [3:0] c);
    return !c[0] && !c[2] && c[1] && c[3];
  endfunction

  function automatic int exp_op();
    if (!m_lvl[3]) return 5;
    if (m_lvl[0]) return m_busy ? 2 : 3;
    if (wcond(m_lvl)) return 1;
    if (m_idle == IDLE) return 4;
    if (!m_lvl[1] && m_lvl[2]) return 0;
    return 2;
  endfunction

  function automatic bit exp_drive();
    return m_lvl[3] && !m_lvl[0] && !m_lvl[1] && m_lvl[2];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = {4'hF, 4'hF}; ah = {'0, '0}; dh = {'0, '0};
      m_lvl = 4'hF; m_prv = 4'hF;
      for (int i = 0; i < 4; i++) m_run[i] = 0;
      m_idle = 0; m_left = 0; m_busy = 0; m_ab = 0; m_stb = 0;
      m_wa = '0; m_wd = '0;
    end else begin
      bit edge_w, act;
      logic [3:0] sv;
      ph.push_front({rp_n, we_n, oe_n, ce_n});
      ah.push_front(addr);
      dh.push_front(din);
      edge_w = wcond(m_prv) && m_lvl[3] && (m_lvl[0] || m_lvl[2]);
      act = (m_lvl != m_prv) || (ah[1] != ah[2]);
      if (act || m_lvl[0] || !m_lvl[3] || m_busy || wcond(m_lvl)) m_idle = 0;
      else if (m_idle < IDLE) m_idle++;
      if (!m_lvl[3]) begin
        if (m_busy) m_ab = 1;
        m_busy = 0;
      end else if (edge_w && !m_busy) begin
        m_busy = 1; m_left = BUSYN; m_ab = 0;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) m_busy = 0;
      end
      m_stb = edge_w;
      if (edge_w) begin m_wa = ah[2]; m_wd = dh[2]; end
      m_prv = m_lvl;
      sv = ph[2];
      for (int i = 0; i < 4; i++) begin
        if (sv[i] != m_lvl[i]) begin
          m_run[i]++;
          if (m_run[i] > FILT) begin m_lvl[i] = sv[i]; m_run[i] = 0; end
        end else m_run[i] = 0;
      end
      while (ph.size() > 3) void'(ph.pop_back());
      while (ah.size() > 3) void'(ah.pop_back());
      while (dh.size() > 3) void'(dh.pop_back());
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1", "op_code", int'(op_code), exp_op());
      chk("R2", "dq_oe", int'(dq_oe), int'(exp_drive()));
      chk("R3", "wr_strobe", int'(wr_strobe), int'(m_stb));
      chk("R3", "wr_addr", int'(wr_addr), int'(m_wa));
      chk("R3", "wr_data", int'(wr_data), int'(m_wd));
      chk("R5", "stby", int'(stby), int'(exp_op() == 3));
      chk("R7", "auto_sb", int'(auto_sb), int'(m_idle == IDLE));
      chk("R6", "busy", int'(busy), int'(m_busy));
      chk("R8", "aborted", int'(aborted), int'(m_ab));
    end
  end

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(logic c, logic o, logic w, logic r);
    ce_n = c; oe_n = o; we_n = w; rp_n = r;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(2);
    // R9 reset state
    chk("R9", "reset op", int'(op_code), 3);
    chk("R9", "reset busy", int'(busy), 0);
    chk("R9", "reset aborted", int'(aborted), 0);
    chk("R9", "reset dq_oe", int'(dq_oe), 0);
    // read, then quiet bus into auto standby (R7)
    pins(0, 0, 1, 1); addr = 8'h10;
    hold(6);
    chk("R9", "read after reset", int'(op_code), 0);
    for (int k = 0; k < 4; k++) begin addr = addr + 1; hold(3); end
    hold(25);
    chk("R7", "auto standby", int'(auto_sb), 1);
    chk("R7", "drive in auto sb", int'(dq_oe), 1);
    addr = 8'h40; hold(5);
    // R4 output enable high
    pins(0, 1, 1, 1); hold(6);
    chk("R4", "oe high hiz", int'(dq_oe), 0);
    // write ended by we rising (R3), then deselect while busy (R6)
    addr = 8'hA5; din = 8'h3C; pins(0, 1, 0, 1); hold(5);
    pins(0, 1, 1, 1); hold(3);
    pins(1, 1, 1, 1); hold(8);
    chk("R6", "deselect while busy", int'(op_code), 2);
    hold(20);
    chk("R6", "standby after busy", int'(op_code), 3);
    // write ended by ce rising first
    addr = 8'h5A; din = 8'hC3; pins(0, 1, 0, 1); hold(5);
    pins(1, 1, 0, 1); hold(2); pins(1, 1, 1, 1); hold(30);
    // glitches (R10)
    pins(0, 1, 1, 1); hold(1); pins(1, 1, 1, 1); hold(6);
    chk("R10", "ce glitch ignored", int'(op_code), 3);
    pins(0, 0, 1, 1); hold(6);
    we_n = 0; hold(1); we_n = 1; hold(6);
    chk("R10", "we glitch no strobe", int'(busy), 0);
    // reset during busy (R8)
    addr = 8'h77; din = 8'h11; pins(0, 1, 0, 1); hold(4);
    pins(0, 1, 1, 1); hold(6);
    rp_n = 0; hold(6);
    chk("R8", "abort flag", int'(aborted), 1);
    chk("R8", "reset op", int'(op_code), 5);
    rp_n = 1; hold(6);
    // random traffic
    for (int it = 0; it < 1500; it++) begin
      logic [3:0] r;
      r = 4'($urandom);
      pins(r[0], r[1], r[2], ($urandom % 16) != 0);
      if ($urandom % 3 == 0) addr = 8'($urandom % 4);
      din = 8'($urandom);
      hold(1 + int'($urandom % 5));
    end
    pins(1, 1, 1, 1); hold(40);
    finish_run();
  end

endmodule